// File: doc/BRIEF.md
# Associative Search Table with Learn

This block is a small content-addressable lookup table. A host talks to it over a command bus with a valid qualifier and a wide data input. The two low command bits pick one of four operations. Read and write reach a single entry by address. Search compares a key against every occupied entry. Learn stores a key in the first free slot without the host having to track free slots.

Bit 0 of every entry is an occupancy flag. Reset clears every entry. The block finds free slots for learn from the occupancy flags, and it raises a full indication when no slot is free. Search results come out as a success flag, a qualifying valid strobe and the index of the winning entry. They leave the block a fixed number of clocks after the search command, so they line up with an associated-data lookup that the host runs alongside.

Top module: `cam_learn_table`

## Requirements
- R1: While and after the active-low reset `rst_n` is low, every entry reads as zero, `table_full`, `rd_ack`, `hit_valid` and `hit_flag` are 0, and every entry counts as empty.
- R2: A command is sampled on a rising clock edge when `cmd_valid` is 1. `cmd[1:0]` selects the operation: 2'b00 read, 2'b01 write, 2'b10 search, 2'b11 learn. For read and write, the entry address is `cmd[2 +: clog2(DEPTH)]`. A write stores all of `data_in`, including bit 0, at that address.
- R3: A read presents the addressed entry on `rd_data` one clock after the command edge. `rd_ack` is high for exactly that one cycle, and it is never high except after a read.
- R4: While `cmd_valid` is 0, the command bus and `data_in` have no effect on the stored entries or on any output.
- R5: `hit_valid` pulses for one cycle, SRCH_LAT (default 2) clock edges after the search command edge. `hit_flag` is high only while `hit_valid` is high.
- R6: A search matches an entry only if its bit 0 is 1 and its bits [ENTRY_W-1:1] equal those of the key. Bit 0 of the key is ignored.
- R7: When several entries match, the lowest index wins and appears on `hit_index` together with `hit_flag`. On a miss, `hit_index` is 0.
- R8: Learn writes `data_in` with bit 0 forced to 1 into the lowest-indexed entry whose bit 0 is 0.
- R9: `table_full` is 1 exactly when bit 0 is 1 in every entry. A learn issued while `table_full` is 1 changes no entry.
- R10: A write with bit 0 of the data at 0 frees that slot: `table_full` drops, and that slot can be taken by a later learn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Qualifies `cmd` for this cycle |
| cmd | input | CMD_W (9) | Operation in [1:0], parameters in the upper bits |
| data_in | input | ENTRY_W (68) | Write data, learn data or search key |
| rd_data | output | ENTRY_W (68) | Entry returned by a read |
| rd_ack | output | 1 | One-cycle strobe marking valid `rd_data` |
| hit_valid | output | 1 | Strobe qualifying a search result |
| hit_flag | output | 1 | Search found a match |
| hit_index | output | clog2(DEPTH) | Lowest matching entry index |
| table_full | output | 1 | Every entry is occupied |

## Verification
The assertions assume that `cmd_valid` is held low throughout reset. They also assume that every input is driven to a known level from the first clock edge onward, because several properties look one or two cycles into the past at the command bus. The bench meets both assumptions: it drives every input to zero at time zero, it changes inputs only on falling edges, and it drops `cmd_valid` after each single-cycle command. The sweeps cover every address and every learn slot of the default 16-entry table, and the bench predicts each result from its own model of the entries.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic [1:0] {
      OP_READ   = 2'b00,
      OP_WRITE  = 2'b01,
      OP_SEARCH = 2'b10,
      OP_LEARN  = 2'b11
   } cam_op_e;
endpackage

// File: rtl/cam_prio_enc.sv
// Lowest-index-wins priority encoder; index is zero when nothing requests.
module cam_prio_enc #(
   parameter int N  = 16,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/cam_entry_array.sv
// Entry storage: one register per slot, single write port, all slots visible.
module cam_entry_array #(
   parameter int DEPTH = 16,
   parameter int W     = 68,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [W-1:0]              wdata,
   output logic [DEPTH-1:0][W-1:0]   entries
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entries[g] <= '0;
         end else if (we && (waddr == AW'(g))) begin
            entries[g] <= wdata;
         end
      end
   end
endmodule

// File: rtl/cam_match.sv
// Per-slot comparators; only occupied slots (bit 0 set) may match.
module cam_match #(
   parameter int DEPTH = 16,
   parameter int W     = 68
) (
   input  logic [DEPTH-1:0][W-1:0] entries,
   input  logic [W-1:1]            key,
   output logic [DEPTH-1:0]        hit
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = entries[g][0] && (entries[g][W-1:1] == key);
   end
endmodule

// File: rtl/cam_pipe.sv
// Fixed-latency register chain for the search result.
module cam_pipe #(
   parameter int W   = 8,
   parameter int LAT = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [LAT];

   for (genvar k = 0; k < LAT; k++) begin : g_stg
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   end

   assign q = stg[LAT-1];
endmodule

// File: rtl/cam_learn_table.sv
module cam_learn_table #(
   parameter int DEPTH    = 16,
   parameter int ENTRY_W  = 68,
   parameter int CMD_W    = 9,
   parameter int SRCH_LAT = 2,
   localparam int AW      = $clog2(DEPTH),
   localparam int RES_W   = AW + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [CMD_W-1:0]   cmd,
   input  logic [ENTRY_W-1:0] data_in,
   output logic [ENTRY_W-1:0] rd_data,
   output logic               rd_ack,
   output logic               hit_valid,
   output logic               hit_flag,
   output logic [AW-1:0]      hit_index,
   output logic               table_full
);
   import cam_pkg::*;

   // elaboration-time parameter checks
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (AW > CMD_W - 2) begin : g_bad_addr
      $error("command parameter field too narrow for DEPTH");
   end
   if (SRCH_LAT < 1) begin : g_bad_lat
      $error("SRCH_LAT must be at least 1");
   end
   if (ENTRY_W < 2) begin : g_bad_w
      $error("ENTRY_W must be at least 2");
   end

   cam_op_e                      op;
   logic [AW-1:0]                addr;
   logic [DEPTH-1:0][ENTRY_W-1:0] entries;
   logic [DEPTH-1:0]             occ;
   logic                         free_found;
   logic [AW-1:0]                free_idx;
   logic [DEPTH-1:0]             match;
   logic                         match_any;
   logic [AW-1:0]                match_idx;
   logic                         do_write, do_learn, do_read, do_search;
   logic                         we;
   logic [AW-1:0]                waddr;
   logic [ENTRY_W-1:0]           wdata;
   logic [RES_W-1:0]             res_d, res_q;

   assign op   = cam_op_e'(cmd[1:0]);
   assign addr = cmd[2 +: AW];

   // unused upper parameter bits
   if (2 + AW < CMD_W) begin : g_spare
      logic unused_param_bits;
      assign unused_param_bits = ^cmd[CMD_W-1:2+AW];
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_occ
      assign occ[g] = entries[g][0];
   end
   assign table_full = &occ;

   assign do_read   = cmd_valid && (op == OP_READ);
   assign do_write  = cmd_valid && (op == OP_WRITE);
   assign do_search = cmd_valid && (op == OP_SEARCH);
   assign do_learn  = cmd_valid && (op == OP_LEARN) && !table_full;

   cam_prio_enc #(.N(DEPTH), .IW(AW)) u_free (
      .req   (~occ),
      .found (free_found),
      .idx   (free_idx)
   );

   logic unused_free_found;
   assign unused_free_found = free_found;

   assign we    = do_write || do_learn;
   assign waddr = do_write ? addr : free_idx;
   assign wdata = do_write ? data_in : {data_in[ENTRY_W-1:1], 1'b1};

   cam_entry_array #(.DEPTH(DEPTH), .W(ENTRY_W), .AW(AW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .waddr   (waddr),
      .wdata   (wdata),
      .entries (entries)
   );

   // read port: one register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ack  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ack <= do_read;
         if (do_read) rd_data <= entries[addr];
      end
   end

   cam_match #(.DEPTH(DEPTH), .W(ENTRY_W)) u_match (
      .entries (entries),
      .key     (data_in[ENTRY_W-1:1]),
      .hit     (match)
   );

   cam_prio_enc #(.N(DEPTH), .IW(AW)) u_win (
      .req   (match),
      .found (match_any),
      .idx   (match_idx)
   );

   assign res_d = do_search ? {1'b1, match_any, match_idx} : '0;

   cam_pipe #(.W(RES_W), .LAT(SRCH_LAT)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (res_d),
      .q     (res_q)
   );

   assign hit_valid = res_q[AW+1];
   assign hit_flag  = res_q[AW];
   assign hit_index = res_q[AW-1:0];
endmodule

// File: rtl/cam_learn_table_chk.sv
module cam_learn_table_chk #(
   parameter int CMD_W    = 9,
   parameter int AW       = 4,
   parameter int SRCH_LAT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [CMD_W-1:0] cmd,
   input logic             rd_ack,
   input logic             hit_valid,
   input logic             hit_flag,
   input logic [AW-1:0]    hit_index,
   input logic             table_full
);
   logic [SRCH_LAT-1:0] srch_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srch_sh <= '0;
      end else begin
         for (int k = SRCH_LAT - 1; k > 0; k--) srch_sh[k] <= srch_sh[k-1];
         srch_sh[0] <= cmd_valid && (cmd[1:0] == 2'b10);
      end
   end

   AST_READ_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd[1:0] == 2'b00) |=> rd_ack);                        // R3
   AST_ACK_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |-> $past(cmd_valid && cmd[1:0] == 2'b00));                   // R3
   AST_QUIET_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rd_ack);                                              // R4
   AST_SRCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid == srch_sh[SRCH_LAT-1]);                                    // R5
   AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      hit_flag |-> hit_valid);                                              // R5
   AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !hit_flag) |-> hit_index == '0);                        // R7
   AST_LEARN_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd[1:0] == 2'b11 && table_full) |=> table_full);      // R9
   AST_FULL_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(table_full) |-> $past(cmd_valid && cmd[1:0] == 2'b01));        // R10
endmodule

bind cam_learn_table cam_learn_table_chk #(
   .CMD_W    (CMD_W),
   .AW       (AW),
   .SRCH_LAT (SRCH_LAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd        (cmd),
   .rd_ack     (rd_ack),
   .hit_valid  (hit_valid),
   .hit_flag   (hit_flag),
   .hit_index  (hit_index),
   .table_full (table_full)
);

// File: tb/cam_learn_table_tb.sv
module cam_learn_table_tb;
   localparam int D  = 16;
   localparam int W  = 68;
   localparam int CW = 9;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [CW-1:0] cmd = '0;
   logic [W-1:0]  data_in = '0;
   logic [W-1:0]  rd_data;
   logic          rd_ack, hit_valid, hit_flag, table_full;
   logic [AW-1:0] hit_index;

   int n_tests = 0;
   int n_fail  = 0;
   logic [W-1:0] mdl [D];

   always #4 clk = ~clk;

   cam_learn_table #(.DEPTH(D), .ENTRY_W(W), .CMD_W(CW), .SRCH_LAT(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .data_in(data_in), .rd_data(rd_data), .rd_ack(rd_ack),
      .hit_valid(hit_valid), .hit_flag(hit_flag), .hit_index(hit_index),
      .table_full(table_full)
   );

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pat(input int i, input bit occ);
      return {32'hA5A50000 + 32'(i), 35'(i * 7 + 3), occ};
   endfunction

   function automatic logic [W-1:0] lkey(input int j);
      return {36'(j * 13 + 1), 32'hC0DE0000 ^ 32'(j)};
   endfunction

   function automatic bit mdl_full();
      for (int i = 0; i < D; i++) if (!mdl[i][0]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic do_cmd(input logic [1:0] op, input int a, input logic [W-1:0] d);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd       = {7'(a), op};
      data_in   = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd       = '0;
      data_in   = '0;
   endtask

   task automatic wr(input int a, input logic [W-1:0] d);
      do_cmd(2'b01, a, d);
      mdl[a] = d;
   endtask

   task automatic rd_chk(input int a, input string req);
      do_cmd(2'b00, a, '0);
      chk(rd_ack === 1'b1, {req, " rd_ack"}, W'(rd_ack), W'(1));
      chk(rd_data === mdl[a], {req, " rd_data"}, rd_data, mdl[a]);
      @(negedge clk);
      chk(rd_ack === 1'b0, "R3 ack one cycle", W'(rd_ack), W'(0));
   endtask

   task automatic srch_chk(input logic [W-1:0] key, input string req);
      bit             ef = 1'b0;
      logic [AW-1:0]  ei = '0;
      for (int i = D - 1; i >= 0; i--)
         if (mdl[i][0] && mdl[i][W-1:1] == key[W-1:1]) begin
            ef = 1'b1;
            ei = AW'(i);
         end
      do_cmd(2'b10, 0, key);
      chk(hit_valid === 1'b0, "R5 not early", W'(hit_valid), W'(0));
      @(negedge clk);
      chk(hit_valid === 1'b1, {req, " R5 hit_valid"}, W'(hit_valid), W'(1));
      chk(hit_flag === ef, {req, " hit_flag"}, W'(hit_flag), W'(ef));
      chk(hit_index === ei, {req, " hit_index"}, W'(hit_index), W'(ei));
      @(negedge clk);
      chk(hit_valid === 1'b0 && hit_flag === 1'b0, "R5 single pulse",
          W'({hit_valid, hit_flag}), W'(0));
   endtask

   task automatic learn(input logic [W-1:0] key);
      do_cmd(2'b11, 0, key);
      if (!mdl_full()) begin
         for (int i = 0; i < D; i++)
            if (!mdl[i][0]) begin
               mdl[i] = {key[W-1:1], 1'b1};
               break;
            end
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(table_full === 1'b0 && rd_ack === 1'b0 && hit_valid === 1'b0
          && hit_flag === 1'b0, "R1 outputs in reset",
          W'({table_full, rd_ack, hit_valid, hit_flag}), W'(0));
      rst_n = 1'b1;
      for (int i = 0; i < D; i++) mdl[i] = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      do_reset();
      // R1: every entry empty and zero
      for (int i = 0; i < D; i++) rd_chk(i, "R1 reset read");

      // R2 write sweep: even slots occupied, odd slots empty
      for (int i = 0; i < D; i++) wr(i, pat(i, (i % 2) == 0));
      for (int i = 0; i < D; i++) rd_chk(i, "R2 readback");
      chk(table_full === 1'b0, "R9 not full", W'(table_full), W'(0));

      // R6 search sweep: only occupied entries match
      for (int i = 0; i < D; i++) srch_chk(pat(i, 1'b1), "R6 sweep");
      // R6 key bit 0 ignored
      for (int i = 0; i < D; i += 2) srch_chk(pat(i, 1'b0), "R6 key bit0");
      // R7 miss reports index 0
      srch_chk({W{1'b1}}, "R7 miss");

      // R7 duplicates: lowest index wins
      wr(5, pat(2, 1'b1));
      wr(11, pat(2, 1'b1));
      srch_chk(pat(2, 1'b1), "R7 lowest of three");
      wr(2, pat(2, 1'b0));
      srch_chk(pat(2, 1'b1), "R7 after freeing low");

      // R4 no-command cycle is ignored
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd       = {7'(0), 2'b01};
      data_in   = {W{1'b1}};
      @(negedge clk);
      cmd = {7'(0), 2'b00};
      @(negedge clk);
      chk(rd_ack === 1'b0, "R4 no ack without valid", W'(rd_ack), W'(0));
      cmd = {7'(0), 2'b10};
      repeat (2) @(negedge clk);
      chk(hit_valid === 1'b0, "R4 no search without valid", W'(hit_valid), W'(0));
      cmd = '0;
      data_in = '0;
      rd_chk(0, "R4 entry untouched");

      // R8 learn sweep into empty table
      do_reset();
      for (int j = 0; j < D; j++) begin
         learn(lkey(j));
         chk(table_full === mdl_full(), "R9 full tracks occupancy",
             W'(table_full), W'(mdl_full()));
      end
      for (int i = 0; i < D; i++) rd_chk(i, "R8 learned slot");
      chk(table_full === 1'b1, "R9 full", W'(table_full), W'(1));

      // R9 learn while full changes nothing
      learn(lkey(99));
      for (int i = 0; i < D; i++) rd_chk(i, "R9 learn ignored");
      srch_chk(lkey(99), "R9 ignored key absent");

      // R10 free a middle slot, then learn refills it
      wr(6, pat(6, 1'b0));
      chk(table_full === 1'b0, "R10 full drops", W'(table_full), W'(0));
      learn(lkey(42));
      rd_chk(6, "R10 R8 refill slot");
      chk(table_full === 1'b1, "R9 full again", W'(table_full), W'(1));
      srch_chk(lkey(42), "R8 learned key found");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule